// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching one page table entry from memory. Pages are 4 KB: the low twelve address bits select a byte within the page and are carried through unchanged, and the upper twenty bits are the virtual page number. The walker adds the virtual page number, scaled to the 4-byte entry size, to a base register. It issues a single read at that address and looks at the valid flag of the returned entry. It then reports either the physical page number joined to the page offset, or a page fault.

A requester offers a translation when the walker shows it is ready. The walker handles one translation at a time and answers with a one-cycle completion pulse. The memory side allows one read in flight: a one-cycle read strobe with its address, followed some cycles later by a one-cycle data-valid strobe. The table base is loaded through a write port that only accepts writes while the supervisor-mode input is high. A write made in user mode leaves the base as it was and raises a privilege-violation pulse.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, `resp_done`, `mem_rd_req` and `priv_viol` are 0, and the table base is 0.
- R2: The read address is `base + (vaddr[31:12] << 2)` modulo 2^32. It uses the base value held at the clock edge on which the request is accepted.
- R3: Each accepted request produces exactly one `mem_rd_req` pulse, one cycle long, in the cycle right after the accepting edge.
- R4: `req_ready` is 1 only while the walker is idle. A `req_valid` raised while `req_ready` is 0 is ignored and starts no read.
- R5: An entry with bit 31 (valid) set gives `resp_fault` = 0 and `resp_paddr` = `{entry[19:0], vaddr[11:0]}`. Bit 30 (dirty) and bits 29:20 (reserved) have no effect on the result.
- R6: An entry with bit 31 clear gives `resp_fault` = 1 and `resp_paddr` = 0.
- R7: `resp_done` is a one-cycle pulse in the cycle after the edge at which `mem_rd_valid` is seen while a read is outstanding. A `mem_rd_valid` that arrives with no read outstanding, including in the strobe cycle itself, is ignored.
- R8: A write with `sup_mode` = 1 loads `base_wr_data` into the base. The next request that is accepted uses the new value.
- R9: A write with `sup_mode` = 0 leaves the base unchanged and sets `priv_viol` to 1 for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle, request is taken at this edge |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_paddr | output | 32 | Translated physical address, 0 on a fault |
| resp_fault | output | 1 | Page fault, valid with `resp_done` |
| mem_rd_req | output | 1 | One-cycle read strobe for the entry |
| mem_rd_addr | output | 32 | Byte address of the entry |
| mem_rd_valid | input | 1 | Read data present |
| mem_rd_data | input | 32 | Page table entry |
| base_wr_en | input | 1 | Base register write strobe |
| base_wr_data | input | 32 | New table base |
| sup_mode | input | 1 | 1 = supervisor, 0 = user |
| priv_viol | output | 1 | User-mode base write was refused |

## Verification
A corrupted base register shows up on `mem_rd_addr` at the first read strobe after the corruption, one cycle after the next request is accepted. The bench therefore follows each base write with translations whose entry addresses it computes itself. A sequencer stuck in a busy state shows as `req_ready` staying low and no `resp_done`. A sequencer that advances early shows as a second read strobe or a completion that arrives before the data. The timing of every walk is checked cycle by cycle across several memory latencies. A wrongly latched entry or virtual address shows in the same cycle as `resp_done`, as a wrong frame, offset or fault flag. The sweep varies the page number, the offset, the valid bit and the reserved bits so that each bit position is exercised.

// File: rtl/pt_walker_pkg.sv
// Shared definitions for the page table walker.
// Assumes a single-level table and a single outstanding memory read.
package pt_walker_pkg;
    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_REQ  = 2'd1,
        WS_WAIT = 2'd2
    } walk_state_t;
endpackage

// File: rtl/pt_base_reg.sv
// Page table base register with a privilege gate.
// Assumes sup_mode is sampled on the same edge as the write strobe.
module pt_base_reg #(
    parameter int PA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PA_W-1:0] wr_data,
    input  logic            sup_mode,
    output logic [PA_W-1:0] base,
    output logic            priv_viol
);
    // Load the base on supervisor writes; flag refused user writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base      <= '0;
            priv_viol <= 1'b0;
        end else begin
            priv_viol <= wr_en && !sup_mode;
            if (wr_en && sup_mode) begin
                base <= wr_data;
            end
        end
    end
endmodule

// File: rtl/pte_decode.sv
// Splits a fetched entry into a translation result.
// Assumes the physical page number sits in the low bits of the entry.
module pte_decode #(
    parameter int PA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int PTE_W     = 32,
    parameter int VALID_BIT = 31
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [OFF_W-1:0] offset,
    output logic [PA_W-1:0]  paddr,
    output logic             fault
);
    localparam int PPN_W = PA_W - OFF_W;

    logic unused_pte_bits;

    assign unused_pte_bits = ^pte;

    // Build the physical address or the fault indication.
    always_comb begin
        fault = !pte[VALID_BIT];
        paddr = fault ? '0 : {pte[PPN_W-1:0], offset};
    end
endmodule

// File: rtl/pt_walk_ctrl.sv
// Sequencer: accept, issue one entry read, wait for data, respond.
// Assumes memory takes the read strobe in the cycle it is raised.
module pt_walk_ctrl
    import pt_walker_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int PTE_W     = 32,
    parameter int VALID_BIT = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             req_ready,
    input  logic [PA_W-1:0]  base,
    output logic             mem_rd_req,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_valid,
    input  logic [PTE_W-1:0] mem_rd_data,
    output logic             resp_done,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_fault
);
    localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);

    walk_state_t      state;
    logic [VA_W-1:0]  vaddr_q;
    logic [PA_W-1:0]  addr_q;
    logic [PA_W-1:0]  entry_off;
    logic [PA_W-1:0]  dec_paddr;
    logic             dec_fault;

    // Scaled page number taken from the incoming request.
    assign entry_off = PA_W'(req_vaddr[VA_W-1:OFF_W]) << ENTRY_SHIFT;

    // Handshake and memory strobe follow directly from the state.
    assign req_ready   = (state == WS_IDLE);
    assign mem_rd_req  = (state == WS_REQ);
    assign mem_rd_addr = addr_q;

    pte_decode #(
        .PA_W      (PA_W),
        .OFF_W     (OFF_W),
        .PTE_W     (PTE_W),
        .VALID_BIT (VALID_BIT)
    ) u_decode (
        .pte    (mem_rd_data),
        .offset (vaddr_q[OFF_W-1:0]),
        .paddr  (dec_paddr),
        .fault  (dec_fault)
    );

    // Walk sequence and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= WS_IDLE;
            vaddr_q    <= '0;
            addr_q     <= '0;
            resp_done  <= 1'b0;
            resp_paddr <= '0;
            resp_fault <= 1'b0;
        end else begin
            resp_done <= 1'b0;
            case (state)
                WS_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        addr_q  <= base + entry_off;
                        state   <= WS_REQ;
                    end
                end
                WS_REQ: begin
                    state <= WS_WAIT;
                end
                WS_WAIT: begin
                    if (mem_rd_valid) begin
                        resp_done  <= 1'b1;
                        resp_paddr <= dec_paddr;
                        resp_fault <= dec_fault;
                        state      <= WS_IDLE;
                    end
                end
                default: begin
                    state <= WS_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/pt_walker.sv
// Single-level page table walker top: base register plus sequencer.
// Assumes 4 KB pages and 4-byte entries (valid in bit 31).
module pt_walker #(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int PTE_W     = 32,
    parameter int VALID_BIT = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             req_ready,
    output logic             resp_done,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_fault,
    output logic             mem_rd_req,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_valid,
    input  logic [PTE_W-1:0] mem_rd_data,
    input  logic             base_wr_en,
    input  logic [PA_W-1:0]  base_wr_data,
    input  logic             sup_mode,
    output logic             priv_viol
);
    logic [PA_W-1:0] base;

    pt_base_reg #(
        .PA_W (PA_W)
    ) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (base_wr_en),
        .wr_data   (base_wr_data),
        .sup_mode  (sup_mode),
        .base      (base),
        .priv_viol (priv_viol)
    );

    pt_walk_ctrl #(
        .VA_W      (VA_W),
        .PA_W      (PA_W),
        .OFF_W     (OFF_W),
        .PTE_W     (PTE_W),
        .VALID_BIT (VALID_BIT)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_vaddr    (req_vaddr),
        .req_ready    (req_ready),
        .base         (base),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .resp_done    (resp_done),
        .resp_paddr   (resp_paddr),
        .resp_fault   (resp_fault)
    );
endmodule

// File: rtl/pt_walker_chk.sv
// Protocol checker for the walker ports, bound to every pt_walker.
module pt_walker_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            resp_done,
    input logic [PA_W-1:0] resp_paddr,
    input logic            resp_fault,
    input logic            mem_rd_req,
    input logic            mem_rd_valid,
    input logic            base_wr_en,
    input logic            sup_mode,
    input logic            priv_viol
);
    // R3
    accept_issues_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_rd_req);
    // R3
    read_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);
    // R4
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !req_ready);
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done);
    // R7
    done_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |-> $past(mem_rd_valid));
    // R6
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_done && resp_fault) |-> (resp_paddr == '0));
    // R9
    user_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr_en && !sup_mode) |=> priv_viol);
    // R9
    flag_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_viol |-> $past(base_wr_en && !sup_mode));
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .resp_done    (resp_done),
    .resp_paddr   (resp_paddr),
    .resp_fault   (resp_fault),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_valid (mem_rd_valid),
    .base_wr_en   (base_wr_en),
    .sup_mode     (sup_mode),
    .priv_viol    (priv_viol)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic        resp_done;
    logic [31:0] resp_paddr;
    logic        resp_fault;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic        sup_mode = 1'b0;
    logic        priv_viol;

    int checks = 0;
    int errors = 0;
    logic [31:0] cur_base = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker u_pt_walker (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_vaddr    (req_vaddr),
        .req_ready    (req_ready),
        .resp_done    (resp_done),
        .resp_paddr   (resp_paddr),
        .resp_fault   (resp_fault),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .base_wr_en   (base_wr_en),
        .base_wr_data (base_wr_data),
        .sup_mode     (sup_mode),
        .priv_viol    (priv_viol)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_base(input logic [31:0] data, input logic sup);
        @(negedge clk);
        base_wr_en = 1'b1;
        base_wr_data = data;
        sup_mode = sup;
        @(negedge clk);
        base_wr_en = 1'b0;
        if (sup) cur_base = data;
        check(sup ? "R8 no flag on supervisor write" : "R9 flag on user write",
              {31'd0, priv_viol}, {31'd0, !sup});
        @(negedge clk);
        check("R9 flag lasts one cycle", {31'd0, priv_viol}, 32'd0);
    endtask

    // One walk; lat = extra idle cycles before the data, early = stray valid in strobe cycle,
    // poke = request raised while busy.
    task automatic walk(input logic [31:0] va, input logic [31:0] pte, input int lat,
                        input bit early, input bit poke);
        logic [31:0] exp_addr;
        logic [31:0] exp_pa;
        exp_addr = cur_base + {10'd0, va[31:12], 2'b00};
        exp_pa = pte[31] ? {pte[19:0], va[11:0]} : 32'd0;
        @(negedge clk);
        check("R4 ready when idle", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = poke;
        req_vaddr = ~va;
        check("R3 read strobe after accept", {31'd0, mem_rd_req}, 32'd1);
        check("R2 entry address", mem_rd_addr, exp_addr);
        check("R4 not ready while busy", {31'd0, req_ready}, 32'd0);
        if (early) begin
            mem_rd_valid = 1'b1;
            mem_rd_data = ~pte;
        end
        @(negedge clk);
        mem_rd_valid = 1'b0;
        check("R3 strobe lasts one cycle", {31'd0, mem_rd_req}, 32'd0);
        check("R7 stray data ignored", {31'd0, resp_done}, 32'd0);
        for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            check("R7 no done before data", {31'd0, resp_done}, 32'd0);
            check("R4 no second read while busy", {31'd0, mem_rd_req}, 32'd0);
        end
        mem_rd_valid = 1'b1;
        mem_rd_data = pte;
        @(negedge clk);
        mem_rd_valid = 1'b0;
        mem_rd_data = 32'hDEAD_BEEF;
        req_valid = 1'b0;
        check("R7 done after data", {31'd0, resp_done}, 32'd1);
        check(pte[31] ? "R5 fault clear" : "R6 fault set", {31'd0, resp_fault}, {31'd0, !pte[31]});
        check(pte[31] ? "R5 physical address" : "R6 address zero", resp_paddr, exp_pa);
        @(negedge clk);
        check("R7 done lasts one cycle", {31'd0, resp_done}, 32'd0);
        check("R4 poke started no read", {31'd0, mem_rd_req}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] bases [4];
        bases[0] = 32'h0000_0000;
        bases[1] = 32'h0010_0000;
        bases[2] = 32'h8765_4320;
        bases[3] = 32'hFFFF_FF00;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ready after reset", {31'd0, req_ready}, 32'd1);
        check("R1 done low after reset", {31'd0, resp_done}, 32'd0);
        check("R1 strobe low after reset", {31'd0, mem_rd_req}, 32'd0);
        check("R1 flag low after reset", {31'd0, priv_viol}, 32'd0);
        rst_n = 1'b1;
        // R1 base is zero: first walk uses base 0
        walk(32'h0000_3ABC, 32'h8000_0042, 0, 1'b0, 1'b0);
        for (int b = 0; b < 4; b++) begin
            // R9 user write refused, then R8 supervisor write
            write_base(bases[b] ^ 32'h5555_0004, 1'b0);
            walk(32'hFFFF_F000, 32'h8000_0001, 1, 1'b0, 1'b0);
            write_base(bases[b], 1'b1);
            for (int i = 0; i < 96; i++) begin
                logic [19:0] vpn;
                logic [31:0] pte;
                logic [11:0] off;
                vpn = (i < 20) ? (20'd1 << i) : 20'((i * 40503 + b * 977) & 32'hFFFFF);
                if (i == 20) vpn = 20'hFFFFF;
                if (i == 21) vpn = 20'h00000;
                off = 12'((i * 301 + b * 17) & 32'hFFF);
                pte = {i[0] ^ b[0], i[1], 10'((i * 37) & 32'h3FF), 20'(vpn ^ 20'hA5A5A ^ 20'(i))};
                walk({vpn, off}, pte, i % 4, i[2], i[3]);
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule